// File: doc/BRIEF.md
# Pipelined ADC Digital Error Corrector

This block sits behind the analog half of a seven-stage pipelined converter. The first six stages each deliver a redundant three-level decision, and the seventh delivers a plain two-bit flash result. Successive stages resolve the same sample half a clock apart, so stage codes arrive alternately on rising and falling clock edges. The corrector delays each stage's code so that all seven line up in the rising-edge domain. It then adds the overlapping weighted codes into one 8-bit offset-binary word and clamps that word at the top and bottom of its range. The result goes out on a registered parallel bus with a data-valid strobe.

A new sample enters on every clock. Each corrected word leaves a fixed five clocks after its first stage decision. An output-enable input gates the bus in the manner of a three-state driver. When disabled, it parks the data at zero and drops the enable and valid flags. A small control machine has two states. FILL starts at reset and counts rising edges until the pipeline holds real data. The transition FILL to RUN fires on the fifth edge after reset release. RUN is held until the next reset, and the only way back to FILL is reset.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Each redundant stage code is two bits wide: 00 means -1, 01 means 0 and 10 means +1. The unused value 11 is treated exactly as 0.
- R2: With stage i (1 to 6) on stage_code bits [2i-1:2i-2] carrying value d_i, and final flash value f (0 to 3), the output word is 127 + sum of d_i * 2^(7-i) + f, in offset binary.
- R3: A corrected sum above 255 is output as 255, and one below 0 is output as 0. There is no wrap. For example, all six stages at +1 with f = 3 gives 255.
- R4: For a sample whose stage-1 code is captured on rising edge n, the stage-i code is captured at edge n + (i-1)/2. Odd stages are captured on rising edges and even stages on falling edges. The flash code is captured on rising edge n + 3.
- R5: The corrected word for the sample of rising edge n appears on dout after rising edge n + 5. One new sample is accepted per clock.
- R6: After reset release, dvalid stays low through the first five rising edges (edges 0 to 4). It is high after edge 5 whenever out_en is high.
- R7: out_en is sampled on rising edges. While it is low, the next edge leaves dout at 0 and dout_en and dvalid low. Raising it again restores dout_en, dvalid and live data after one edge, with no refill.
- R8: Asserting rst_n low clears dout, dout_en and dvalid at once, without waiting for a clock, and returns the control machine to FILL.
- R9: Different redundant code sets with the same weighted sum produce the same output word. For example, stage 1 at +1 with stage 2 at -1 equals stage 2 at +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges capture stage codes |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_code | input | 12 | Six redundant stage codes, stage 1 in the low two bits |
| flash_code | input | 2 | Final-stage flash result, unsigned 0 to 3 |
| out_en | input | 1 | Output enable, sampled on rising edges |
| dout | output | 8 | Corrected offset-binary word |
| dout_en | output | 1 | High while the output bus is driven |
| dvalid | output | 1 | Data-valid strobe |

## Verification
The checks assume that each stage code is stable around the edge that captures it. Odd stages and the flash code must be steady at rising edges, even stages at falling edges, and out_en at rising edges. The bench keeps within this by driving odd-stage and flash codes just after each falling edge, and even-stage codes just after each rising edge. It feeds every stage the decision belonging to its own sample, offset by that stage's half-cycle lag, so consecutive samples interleave on the bus as they would behind a real pipeline. Any input value, including the unused code 11, is allowed at any time.

// File: rtl/pipe_adc_corrector_pkg.sv
`timescale 1ns/1ps
package pipe_adc_corrector_pkg;

    // Redundant three-level stage decision encodings
    localparam logic [1:0] RC_NEG  = 2'b00;
    localparam logic [1:0] RC_ZERO = 2'b01;
    localparam logic [1:0] RC_POS  = 2'b10;

    typedef enum logic {
        ST_FILL,
        ST_RUN
    } fill_state_e;

    // The unused encoding collapses to a zero decision
    function automatic logic [1:0] rc_clean(input logic [1:0] c);
        return (c == 2'b11) ? RC_ZERO : c;
    endfunction

endpackage

// File: rtl/pipe_adc_deskew.sv
`timescale 1ns/1ps
module pipe_adc_deskew
    import pipe_adc_corrector_pkg::*;
#(
    parameter int NR = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*NR-1:0] st_in,
    input  logic [1:0]      fl_in,
    output logic [2*NR-1:0] st_al,
    output logic [1:0]      fl_al
);
    localparam int HALF = NR / 2;

    for (genvar k = 0; k < NR; k++) begin : g_stage
        if (k % 2 == 0) begin : g_rise
            // odd stage: rising-edge capture, delayed to the alignment edge
            localparam int D = 1 + HALF - k / 2;
            logic [1:0] chain [D];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int j = 0; j < D; j++) chain[j] <= RC_ZERO;
                end else begin
                    chain[0] <= rc_clean(st_in[2*k +: 2]);
                    for (int j = 1; j < D; j++) chain[j] <= chain[j-1];
                end
            end
            assign st_al[2*k +: 2] = chain[D-1];
        end else begin : g_fall
            // even stage: falling-edge capture, re-registered on rising edges
            localparam int D = 1 + HALF - (k + 1) / 2;
            logic [1:0] half_q;
            logic [1:0] chain [D];
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) half_q <= RC_ZERO;
                else        half_q <= rc_clean(st_in[2*k +: 2]);
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int j = 0; j < D; j++) chain[j] <= RC_ZERO;
                end else begin
                    chain[0] <= half_q;
                    for (int j = 1; j < D; j++) chain[j] <= chain[j-1];
                end
            end
            assign st_al[2*k +: 2] = chain[D-1];
        end
    end

    // final flash resolves last, on the alignment edge itself
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_al <= '0;
        else        fl_al <= fl_in;
    end

endmodule

// File: rtl/pipe_adc_combine.sv
`timescale 1ns/1ps
module pipe_adc_combine
    import pipe_adc_corrector_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*(OUT_W-2)-1:0]  st_al,
    input  logic [1:0]              fl_al,
    output logic [OUT_W-1:0]        sum_q
);
    localparam int NR   = OUT_W - 2;
    localparam int SW   = OUT_W + 3;
    localparam int MID  = 2**(OUT_W-1) - 1;
    localparam int MAXV = 2**OUT_W - 1;

    logic signed [SW-1:0] acc;
    logic [OUT_W-1:0]     clamped;

    always_comb begin
        acc = $signed(SW'(MID)) + $signed(SW'(fl_al));
        for (int i = 0; i < NR; i++) begin
            case (st_al[2*i +: 2])
                RC_POS:  acc = acc + $signed(SW'(1) << (OUT_W - 2 - i));
                RC_NEG:  acc = acc - $signed(SW'(1) << (OUT_W - 2 - i));
                default: ;
            endcase
        end
        if (acc[SW-1])                      clamped = '0;
        else if (acc > $signed(SW'(MAXV)))  clamped = '1;
        else                                clamped = acc[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= clamped;
    end

endmodule

// File: rtl/pipe_adc_outctl.sv
`timescale 1ns/1ps
module pipe_adc_outctl
    import pipe_adc_corrector_pkg::*;
#(
    parameter int OUT_W    = 8,
    parameter int FILL_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic [OUT_W-1:0] sum_q,
    output logic [OUT_W-1:0] dout,
    output logic             dout_en,
    output logic             dvalid
);
    localparam int CW = $clog2(FILL_CYC + 1);

    fill_state_e   state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_FILL: begin
                if (cnt == CW'(FILL_CYC - 1)) nxt = ST_RUN;
                else                          cnt_nxt = cnt + 1'b1;
            end
            ST_RUN: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
            dvalid  <= 1'b0;
        end else begin
            dout    <= out_en ? sum_q : '0;
            dout_en <= out_en;
            dvalid  <= out_en && (state == ST_RUN);
        end
    end

endmodule

// File: rtl/pipe_adc_corrector.sv
`timescale 1ns/1ps
module pipe_adc_corrector #(
    parameter int OUT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*OUT_W-5:0]     stage_code,
    input  logic [1:0]             flash_code,
    input  logic                   out_en,
    output logic [OUT_W-1:0]       dout,
    output logic                   dout_en,
    output logic                   dvalid
);
    localparam int NR       = OUT_W - 2;
    localparam int FILL_CYC = NR / 2 + 2;

    logic [2*NR-1:0]  al_codes;
    logic [1:0]       al_flash;
    logic [OUT_W-1:0] sum_q;

    pipe_adc_deskew #(.NR(NR)) deskew_i (
        .clk   (clk),
        .rst_n (rst_n),
        .st_in (stage_code),
        .fl_in (flash_code),
        .st_al (al_codes),
        .fl_al (al_flash)
    );

    pipe_adc_combine #(.OUT_W(OUT_W)) combine_i (
        .clk   (clk),
        .rst_n (rst_n),
        .st_al (al_codes),
        .fl_al (al_flash),
        .sum_q (sum_q)
    );

    pipe_adc_outctl #(.OUT_W(OUT_W), .FILL_CYC(FILL_CYC)) outctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .out_en  (out_en),
        .sum_q   (sum_q),
        .dout    (dout),
        .dout_en (dout_en),
        .dvalid  (dvalid)
    );

endmodule

// File: rtl/pipe_adc_corrector_chk.sv
`timescale 1ns/1ps
module pipe_adc_corrector_chk #(
    parameter int OUT_W    = 8,
    parameter int FILL_CYC = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    out_en,
    input logic [OUT_W-1:0]        dout,
    input logic                    dout_en,
    input logic                    dvalid,
    input logic [2*(OUT_W-2)-1:0]  al_codes,
    input logic [1:0]              al_flash,
    input logic [OUT_W-1:0]        sum_q
);
    localparam int NR = OUT_W - 2;
    localparam int CW = $clog2(FILL_CYC + 1);
    localparam logic [2*NR-1:0] ALL_POS = {NR{2'b10}};

    logic [CW-1:0] edges;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         edges <= '0;
        else if (edges != CW'(FILL_CYC))    edges <= edges + 1'b1;
    end

    for (genvar k = 0; k < NR; k++) begin : g_code
        assert_no_illegal_R1: assert property (@(posedge clk) disable iff (!rst_n)
            al_codes[2*k +: 2] != 2'b11)
            else $error("illegal aligned code in stage %0d", k + 1);
    end

    assert_overrange_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (al_codes == ALL_POS && al_flash == 2'b11) |=> (sum_q == '1))
        else $error("overrange sum not clamped to full scale");

    assert_fill_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edges < CW'(FILL_CYC)) |-> !dvalid)
        else $error("dvalid high before pipeline filled");

    assert_valid_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> dout_en)
        else $error("dvalid without output enable");

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(out_en) |-> (dout == '0 && !dout_en && !dvalid))
        else $error("outputs active while disabled");

endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(.OUT_W(OUT_W), .FILL_CYC(FILL_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_en   (out_en),
    .dout     (dout),
    .dout_en  (dout_en),
    .dvalid   (dvalid),
    .al_codes (al_codes),
    .al_flash (al_flash),
    .sum_q    (sum_q)
);

// File: tb/pipe_adc_corrector_tb_top.sv
`timescale 1ns/1ps
module pipe_adc_corrector_tb_top;

    localparam logic [1:0] M = 2'b00;
    localparam logic [1:0] Z = 2'b01;
    localparam logic [1:0] P = 2'b10;
    localparam logic [1:0] X = 2'b11;
    localparam int NV = 14;

    // {expected[7:0], flash[1:0], s6, s5, s4, s3, s2, s1}
    localparam logic [21:0] VEC [NV] = '{
        {8'd127, 2'd0, Z, Z, Z, Z, Z, Z},
        {8'd128, 2'd1, Z, Z, Z, Z, Z, Z},
        {8'd255, 2'd3, P, P, P, P, P, P},
        {8'd1,   2'd0, M, M, M, M, M, M},
        {8'd255, 2'd2, P, P, P, P, P, P},
        {8'd191, 2'd0, Z, Z, Z, Z, Z, P},
        {8'd96,  2'd1, Z, Z, Z, Z, P, M},
        {8'd108, 2'd3, M, P, M, P, M, Z},
        {8'd161, 2'd2, Z, Z, Z, Z, M, P},
        {8'd161, 2'd2, Z, Z, Z, Z, P, Z},
        {8'd127, 2'd0, Z, Z, Z, Z, Z, X},
        {8'd192, 2'd1, Z, Z, Z, X, Z, P},
        {8'd132, 2'd3, P, Z, Z, Z, Z, Z},
        {8'd5,   2'd0, P, M, M, M, M, M}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] stage_code = {6{Z}};
    logic [1:0]  flash_code = 2'd0;
    logic        out_en = 1'b1;
    logic [7:0]  dout;
    logic        dout_en;
    logic        dvalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pipe_adc_corrector dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_code (stage_code),
        .flash_code (flash_code),
        .out_en     (out_en),
        .dout       (dout),
        .dout_en    (dout_en),
        .dvalid     (dvalid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] code_at(input int idx, input int k);
        if (idx >= 0 && idx < NV) return VEC[idx][2*k +: 2];
        return Z;
    endfunction

    function automatic logic [1:0] flash_at(input int idx);
        if (idx >= 0 && idx < NV) return VEC[idx][13:12];
        return 2'd0;
    endfunction

    function automatic string tag_of(input int idx);
        if (idx == 2 || idx == 4)  return "R3 saturation";
        if (idx == 10 || idx == 11) return "R1 illegal code";
        if (idx == 8 || idx == 9)  return "R9 redundancy";
        return "R2 R4 R5 vector";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset dout", 16'(dout), 16'd0);
        check("R8 reset dout_en", 16'(dout_en), 16'd0);
        check("R8 reset dvalid", 16'(dvalid), 16'd0);
        rst_n = 1'b1;

        // table walk: back-to-back samples, each stage fed at its own lag
        for (int t = 0; t < NV + 5; t++) begin
            @(negedge clk); #0.5;
            for (int k = 0; k < 6; k += 2) stage_code[2*k +: 2] = code_at(t - k / 2, k);
            flash_code = flash_at(t - 3);
            @(posedge clk); #0.5;
            for (int k = 1; k < 6; k += 2) stage_code[2*k +: 2] = code_at(t - (k - 1) / 2, k);
            #0.5;
            check("R6 fill dvalid", 16'(dvalid), (t < 5) ? 16'd0 : 16'd1);
            if (t >= 5) check(tag_of(t - 5), 16'(dout), 16'(VEC[t - 5][21:14]));
        end

        // R7: disable, then re-enable without refill
        @(negedge clk); #0.5; out_en = 1'b0;
        @(posedge clk); #1;
        check("R7 disabled dout", 16'(dout), 16'd0);
        check("R7 disabled dout_en", 16'(dout_en), 16'd0);
        check("R7 disabled dvalid", 16'(dvalid), 16'd0);
        @(negedge clk); #0.5; out_en = 1'b1;
        @(posedge clk); #1;
        check("R7 re-enabled dout_en", 16'(dout_en), 16'd1);
        check("R7 re-enabled dvalid", 16'(dvalid), 16'd1);
        check("R7 re-enabled dout", 16'(dout), 16'd127);

        // R3: steady overrange input
        @(negedge clk); #0.5;
        stage_code = {6{P}}; flash_code = 2'd3;
        repeat (7) @(posedge clk);
        #1;
        check("R3 steady overrange", 16'(dout), 16'd255);

        // R2: steady bottom of range
        @(negedge clk); #0.5;
        stage_code = {6{M}}; flash_code = 2'd0;
        repeat (7) @(posedge clk);
        #1;
        check("R2 steady low end", 16'(dout), 16'd1);

        // R8: asynchronous reset mid-run, then refill
        @(negedge clk); #0.5; rst_n = 1'b0;
        #0.5;
        check("R8 async dout", 16'(dout), 16'd0);
        check("R8 async dout_en", 16'(dout_en), 16'd0);
        check("R8 async dvalid", 16'(dvalid), 16'd0);
        @(posedge clk); #1; rst_n = 1'b1;
        for (int e = 0; e < 6; e++) begin
            @(posedge clk); #1;
            check("R6 refill dvalid", 16'(dvalid), (e < 5) ? 16'd0 : 16'd1);
        end
        check("R5 R8 refill data", 16'(dout), 16'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule